// File: doc/BRIEF.md
# Masked Input Change Interrupt Detector

This block watches every line of a 32-line I/O port and flags a pin when its sampled level changes. Each clock it compares the current input with the sample taken one clock earlier. A detection therefore needs the clock to be running. Detection runs on every pin, whatever that pin is being used for: a plain input, a line the port drives, or a line handed over to a peripheral.

Each pin starts in any-edge mode, where a rise or a fall marks an event. A pin whose additional-mode bit is set switches to one of two modes. In edge mode it reacts to one edge direction only. In level mode it reacts to one input level, and it re-flags the pin on every clock while that level holds.

Events collect in sticky status bits, and the mask has no effect on them. Reading the status register returns all the bits and clears them. The interrupt line is a registered OR of the status bits that the mask lets through. The mask and the three mode vectors are each written through a pair of registers: one sets bits, the other clears them. A third address reads each vector back.

Top module: `pin_change_irq`

## Requirements
- R1: A write to address 0 sets the mask bits where the write data is 1. A write to address 1 clears those bits. A read at address 2 returns the mask. All other mask bits keep their value.
- R2: A write to address 3 sets additional-mode bits, and a write to address 4 clears them. A read at address 5 returns them. A pin with its bit at 0 uses any-edge detection.
- R3: A write to address 6 selects level sensing for the pins where the data is 1. A write to address 7 selects edge sensing for them. A read at address 8 returns the selection, with 1 meaning level.
- R4: A write to address 9 selects high/rising polarity, and a write to address 10 selects low/falling. A read at address 11 returns the polarity, with 1 meaning high/rising.
- R5: In any-edge mode, a pin whose value differs from its value one clock earlier gets its status bit set at that clock edge.
- R6: In additional edge mode, only the selected direction of change sets the status bit.
- R7: In additional level mode, the status bit is set at every clock edge where the pin is at the selected level. It is set again after a status read for as long as the level holds.
- R8: Status bits are sticky and are set whatever the mask holds. A read at address 12 returns the status and clears it. An event in the same cycle as the read is kept. Reads at addresses 13 to 15 and at the write-only addresses return 0.
- R9: The irq output equals the OR over all pins of status AND mask, as they stood one clock earlier.
- R10: While reset is held, the mask, mode and status registers are zero, and the previous-sample register loads the current input. A steady input level at reset release therefore reports no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | NPINS | Filtered pin levels |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; a read at the status address clears the status |
| addr_i | input | 4 | Register address |
| wdata_i | input | NPINS | Write data, one bit per pin |
| rdata_o | output | NPINS | Read data for addr_i, combinational |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The properties assume the following about the inputs:
- A write strobe and a read strobe never act on the same register in the same cycle.
- Pin levels are already synchronous to the clock when they arrive.

The bench keeps to these assumptions by changing pins, strobes and addresses only on the falling edge. It also never raises more than one strobe in a cycle. The random phase writes only to set or clear addresses and reads only at readback or status addresses. It flips a few pins at a time, so that edge, level and sticky behaviour all stay visible between status reads.

// File: rtl/pci_pkg.sv
package pci_pkg;
    localparam int ADDR_W = 4;
    localparam int NVEC   = 4;   // mask, additional mode, kind, polarity

    localparam logic [ADDR_W-1:0] A_MSK_SET = 4'd0;
    localparam logic [ADDR_W-1:0] A_MSK_CLR = 4'd1;
    localparam logic [ADDR_W-1:0] A_MSK_RD  = 4'd2;
    localparam logic [ADDR_W-1:0] A_AUX_SET = 4'd3;
    localparam logic [ADDR_W-1:0] A_AUX_CLR = 4'd4;
    localparam logic [ADDR_W-1:0] A_AUX_RD  = 4'd5;
    localparam logic [ADDR_W-1:0] A_LVL_SET = 4'd6;
    localparam logic [ADDR_W-1:0] A_EDG_SET = 4'd7;
    localparam logic [ADDR_W-1:0] A_KND_RD  = 4'd8;
    localparam logic [ADDR_W-1:0] A_HI_SET  = 4'd9;
    localparam logic [ADDR_W-1:0] A_LO_SET  = 4'd10;
    localparam logic [ADDR_W-1:0] A_POL_RD  = 4'd11;
    localparam logic [ADDR_W-1:0] A_STA_RD  = 4'd12;

    typedef enum logic [1:0] {
        MODE_ANY_EDGE = 2'd0,
        MODE_ONE_EDGE = 2'd1,
        MODE_LEVEL    = 2'd2
    } det_mode_e;
endpackage

// File: rtl/pci_setclr_reg.sv
module pci_setclr_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= (q_r | set_i) & ~clr_i;
    end

    assign q_o = q_r;
endmodule

// File: rtl/pci_detect.sv
module pci_detect
    import pci_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic [N-1:0] pin_i,
    input  logic [N-1:0] aux_i,
    input  logic [N-1:0] kind_i,
    input  logic [N-1:0] pol_i,
    output logic [N-1:0] prev_o,
    output logic [N-1:0] evt_o
);
    logic [N-1:0] prev_r;

    // Loads the live input every cycle, reset included, so release sees no edge.
    always_ff @(posedge clk) prev_r <= pin_i;

    assign prev_o = prev_r;

    for (genvar i = 0; i < N; i++) begin : g_pin
        det_mode_e mode;
        logic      rise;
        logic      fall;

        assign rise = pin_i[i] & ~prev_r[i];
        assign fall = ~pin_i[i] & prev_r[i];

        always_comb begin
            if (!aux_i[i])     mode = MODE_ANY_EDGE;
            else if (kind_i[i]) mode = MODE_LEVEL;
            else                mode = MODE_ONE_EDGE;
        end

        always_comb begin
            unique case (mode)
                MODE_ANY_EDGE: evt_o[i] = rise | fall;
                MODE_ONE_EDGE: evt_o[i] = pol_i[i] ? rise : fall;
                MODE_LEVEL:    evt_o[i] = pol_i[i] ? pin_i[i] : ~pin_i[i];
                default:       evt_o[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pci_status.sv
module pci_status #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] mask_i,
    input  logic         clr_i,
    output logic [N-1:0] status_o,
    output logic         irq_o
);
    logic [N-1:0] sta_r;
    logic         irq_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            sta_r <= '0;
            irq_r <= 1'b0;
        end else begin
            sta_r <= (clr_i ? '0 : sta_r) | evt_i;
            irq_r <= |(sta_r & mask_i);
        end
    end

    assign status_o = sta_r;
    assign irq_o    = irq_r;
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
    import pci_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_i,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [3:0]       addr_i,
    input  logic [NPINS-1:0] wdata_i,
    output logic [NPINS-1:0] rdata_o,
    output logic             irq_o
);
    localparam logic [ADDR_W-1:0] SET_A [NVEC] = '{A_MSK_SET, A_AUX_SET, A_LVL_SET, A_HI_SET};
    localparam logic [ADDR_W-1:0] CLR_A [NVEC] = '{A_MSK_CLR, A_AUX_CLR, A_EDG_SET, A_LO_SET};

    logic [NPINS-1:0] vec_q [NVEC];
    logic [NPINS-1:0] prev_w;
    logic [NPINS-1:0] evt_w;
    logic [NPINS-1:0] status_w;
    logic             sta_clr;

    for (genvar v = 0; v < NVEC; v++) begin : g_vec
        logic [NPINS-1:0] set_v;
        logic [NPINS-1:0] clr_v;

        assign set_v = (wr_en_i && addr_i == SET_A[v]) ? wdata_i : '0;
        assign clr_v = (wr_en_i && addr_i == CLR_A[v]) ? wdata_i : '0;

        pci_setclr_reg #(.W(NPINS)) u_reg (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_v),
            .clr_i (clr_v),
            .q_o   (vec_q[v])
        );
    end

    pci_detect #(.N(NPINS)) u_det (
        .clk    (clk),
        .pin_i  (pin_i),
        .aux_i  (vec_q[1]),
        .kind_i (vec_q[2]),
        .pol_i  (vec_q[3]),
        .prev_o (prev_w),
        .evt_o  (evt_w)
    );

    assign sta_clr = rd_en_i && (addr_i == A_STA_RD);

    pci_status #(.N(NPINS)) u_sta (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt_w),
        .mask_i   (vec_q[0]),
        .clr_i    (sta_clr),
        .status_o (status_w),
        .irq_o    (irq_o)
    );

    always_comb begin
        case (addr_i)
            A_MSK_RD: rdata_o = vec_q[0];
            A_AUX_RD: rdata_o = vec_q[1];
            A_KND_RD: rdata_o = vec_q[2];
            A_POL_RD: rdata_o = vec_q[3];
            A_STA_RD: rdata_o = status_w;
            default:  rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic [3:0]       addr,
    input logic [NPINS-1:0] wdata,
    input logic [NPINS-1:0] pin,
    input logic [NPINS-1:0] prev,
    input logic [NPINS-1:0] mask,
    input logic [NPINS-1:0] aux,
    input logic [NPINS-1:0] kind,
    input logic [NPINS-1:0] pol,
    input logic [NPINS-1:0] status,
    input logic             irq
);
    AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 4'd0) |=> ((mask & $past(wdata)) == $past(wdata))); // R1
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 4'd1) |=> ((mask & $past(wdata)) == '0)); // R1
    AST_ANY_EDGE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past((pin ^ prev) & ~aux) & ~status) == '0)); // R5
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(aux & kind & ~(pin ^ pol)) & ~status) == '0)); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && addr == 4'd12) |=> ((status & $past(status)) == $past(status))); // R8
    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|(status & mask)))); // R9
endmodule

bind pin_change_irq pin_change_irq_chk #(.NPINS(NPINS)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en_i),
    .rd_en  (rd_en_i),
    .addr   (addr_i),
    .wdata  (wdata_i),
    .pin    (pin_i),
    .prev   (prev_w),
    .mask   (vec_q[0]),
    .aux    (vec_q[1]),
    .kind   (vec_q[2]),
    .pol    (vec_q[3]),
    .status (status_w),
    .irq    (irq_o)
);

// File: tb/pin_change_irq_tb_top.sv
`timescale 1ns/1ps
module pin_change_irq_tb_top;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pin = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [3:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq;

    int errors = 0;
    int checks = 0;

    // model state
    logic [N-1:0] m_mask, m_aux, m_kind, m_pol, m_prev, m_sta;
    logic         m_irq;

    always #10 clk = ~clk;

    pin_change_irq #(.NPINS(N)) dut_i (
        .clk(clk), .rst(rst), .pin_i(pin), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [N-1:0] model_evt();
        logic [N-1:0] e;
        for (int i = 0; i < N; i++) begin
            if (!m_aux[i])      e[i] = pin[i] ^ m_prev[i];
            else if (m_kind[i]) e[i] = m_pol[i] ? pin[i] : ~pin[i];
            else                e[i] = m_pol[i] ? (pin[i] & ~m_prev[i]) : (~pin[i] & m_prev[i]);
        end
        return e;
    endfunction

    function automatic logic [N-1:0] model_rd(input logic [3:0] a);
        case (a)
            4'd2:    return m_mask;
            4'd5:    return m_aux;
            4'd8:    return m_kind;
            4'd11:   return m_pol;
            4'd12:   return m_sta;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock with the inputs currently driven; model advances alongside
    task automatic tick();
        logic [N-1:0] evt, sta_n;
        logic         irq_n;
        evt   = model_evt();
        irq_n = |(m_sta & m_mask);
        sta_n = ((rd_en && addr == 4'd12) ? '0 : m_sta) | evt;
        if (wr_en) begin
            case (addr)
                4'd0:  m_mask = m_mask | wdata;
                4'd1:  m_mask = m_mask & ~wdata;
                4'd3:  m_aux  = m_aux | wdata;
                4'd4:  m_aux  = m_aux & ~wdata;
                4'd6:  m_kind = m_kind | wdata;
                4'd7:  m_kind = m_kind & ~wdata;
                4'd9:  m_pol  = m_pol | wdata;
                4'd10: m_pol  = m_pol & ~wdata;
                default: ;
            endcase
        end
        m_sta  = sta_n;
        m_irq  = irq_n;
        m_prev = pin;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        check("R9 irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, m_irq});
    endtask

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
    endtask

    task automatic rd(input string req, input logic [3:0] a);
        rd_en = 1'b1; addr = a;
        #1;
        check(req, rdata, model_rd(a));
        tick();
    endtask

    initial begin
        void'($urandom(32'd4711));
        pin = 32'hA5A5_0F0F;
        m_mask = '0; m_aux = '0; m_kind = '0; m_pol = '0; m_sta = '0; m_irq = 1'b0;
        repeat (3) @(negedge clk);
        m_prev = pin;
        rst = 1'b0;
        tick(); tick();
        // R10: no false event from the level held through reset, registers cleared
        rd("R10 status after reset", 4'd12);
        rd("R10 mask after reset", 4'd2);
        rd("R10 mode after reset", 4'd5);
        // R1 mask pair
        wr(4'd0, 32'hF0F0_00FF);
        rd("R1 mask set", 4'd2);
        wr(4'd1, 32'h0000_00F0);
        rd("R1 mask clear", 4'd2);
        // R5 any-edge on bit 3 (masked -> irq)
        pin[3] = 1'b0; tick();
        rd("R5 fall", 4'd12);
        pin[3] = 1'b1; tick(); tick(); tick();
        rd("R5 rise sticky", 4'd12);
        rd("R8 cleared by read", 4'd12);
        rd("R8 unused address", 4'd14);
        // R2/R4/R6 rising-only on bit 20
        wr(4'd3, 32'h0010_0040);
        rd("R2 aux set", 4'd5);
        wr(4'd9, 32'h0010_0000);
        rd("R4 polarity", 4'd11);
        pin[20] = 1'b1; tick();
        rd("R6 rising edge", 4'd12);
        pin[20] = 1'b0; tick();
        rd("R6 falling ignored", 4'd12);
        // R3/R7 low level on bit 6
        wr(4'd6, 32'h0000_0040);
        rd("R3 kind", 4'd8);
        pin[6] = 1'b0; tick(); tick();
        rd("R7 level set", 4'd12);
        rd("R7 level re-sets after read", 4'd12);
        pin[6] = 1'b1; tick();
        rd("R7 level gone", 4'd12);
        rd("R7 level stays clear", 4'd12);
        wr(4'd7, 32'h0000_0040);
        rd("R3 kind back to edge", 4'd8);
        wr(4'd4, 32'h0000_0040);
        rd("R2 aux clear", 4'd5);
        // random phase
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom_range(0, 9);
            if ($urandom_range(0, 3) == 0) pin[$urandom_range(0, N - 1)] ^= 1'b1;
            if (r < 3) begin
                logic [3:0] wa;
                case ($urandom_range(0, 7))
                    0: wa = 4'd0; 1: wa = 4'd1; 2: wa = 4'd3; 3: wa = 4'd4;
                    4: wa = 4'd6; 5: wa = 4'd7; 6: wa = 4'd9; default: wa = 4'd10;
                endcase
                wr(wa, $urandom() & $urandom());
            end else if (r < 5) begin
                logic [3:0] ra;
                case ($urandom_range(0, 4))
                    0: ra = 4'd2; 1: ra = 4'd5; 2: ra = 4'd8; 3: ra = 4'd11; default: ra = 4'd12;
                endcase
                rd("R8 random readback", ra);
            end else begin
                tick();
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule